// File: doc/BRIEF.md
# Descriptor Chain Host-Error Checker

This block watches the buffer descriptors that a DMA engine fetches while it walks transmit and receive descriptor chains. For each accepted descriptor it checks the start, ownership, pointer and length fields. On a transmit chain it also adds up the buffer lengths of a packet and compares the total with the packet length declared in the first descriptor.

The first fault found on each direction is latched as a 4-bit error code together with the channel that caused it. Any latched code raises a host-error interrupt. Recovery takes a hardware reset. The one exception is the transmit channel field, which returns to 0 when the host reads the status word.

A read-only 32-bit status word packs the following fields at fixed bit positions:
- an idle flag;
- the transmit error code and channel;
- the receive error code and channel.

Top module: `desc_err_chk`

## Requirements
- R1: The status word holds the idle flag at bit 31, the transmit code at bits 23:20, the transmit channel at 18:16, the receive code at 15:12 and the receive channel at 10:8. Every other bit reads 0.
- R2: The idle flag (bit 31) reads 0 while reset is held and reads 1 one cycle after release. It reads 0 in the cycle after any descriptor is accepted (desc_valid high at a clock edge). It also reads 0 while a packet is open, meaning its last descriptor (EOP) has not been accepted yet. It returns to 1 once no descriptor is presented and no packet is open.
- R3: A transmit descriptor (desc_is_rx=0) is checked against the following codes:
  - 1: it opens a packet (no packet open) but its SOP flag is clear.
  - 2: it opens a packet and its ownership flag is clear.
  - 3: its EOP flag is clear and its next pointer is 0.
  - 4: its buffer pointer is 0.
  - 5: its buffer length is 0.
- R4: A transmit descriptor with EOP set yields code 6 when both of these hold: the packet length from the packet's SOP descriptor is nonzero, and the sum of the packet's buffer lengths is below it. A sum equal to or above the declared length is not an error. A declared length of 0 is never flagged. A descriptor carrying SOP restarts the sum.
- R5: When one descriptor fails several checks, the lowest-numbered code among them is reported.
- R6: Each direction keeps its first nonzero code and channel until reset. Later faulty descriptors leave both unchanged.
- R7: The transmit channel field (bits 18:16) gives the channel of the faulty transmit descriptor. A host read pulse (stat_rd) clears it to 0 at the next edge, while the transmit code is kept. A fault latched at the same edge as a read takes precedence over the clear.
- R8: A receive descriptor (desc_is_rx=1) is checked only for two faults: code 2, when it opens a packet with ownership clear, and code 4, when its buffer pointer is 0. Its channel is reported at bits 10:8 and a read does not clear it.
- R9: host_err_irq is high from the cycle after a fault is latched until reset, and low while both codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| desc_valid | input | 1 | A descriptor is presented this cycle |
| desc_is_rx | input | 1 | 1 for a receive descriptor, 0 for transmit |
| desc_chan | input | 3 | Channel of the descriptor |
| desc_buf_ptr | input | 32 | Buffer pointer |
| desc_buf_len | input | 16 | Buffer length |
| desc_pkt_len | input | 16 | Declared packet length (meaningful on SOP) |
| desc_sop | input | 1 | Start-of-packet flag |
| desc_eop | input | 1 | End-of-packet flag |
| desc_own | input | 1 | Ownership flag |
| desc_next_ptr | input | 32 | Next descriptor pointer |
| stat_rd | input | 1 | Host read strobe of the status word |
| stat_word | output | 32 | Packed status word |
| host_err_irq | output | 1 | Sticky host-error interrupt |

## Verification
The checks are driven with several kinds of descriptor stream, each aimed at a different decision in the block:
- Clean three-buffer chains, which tell proper packet tracking and idle behaviour apart from false alarms.
- Single descriptors carrying exactly one fault each, which separate the transmit codes one from another.
- Descriptors with several faults at once, which expose the priority order.
- Length sums just below, equal to, and with a declared length of zero, which bound the short-packet comparison.
- A second fault after the first, and host reads, which prove stickiness and the channel clear.
- Receive descriptors that would be faults on transmit, which show the narrower receive rule set.

// File: rtl/desc_chk_pkg.sv
package desc_chk_pkg;

    localparam int CODE_W  = 4;
    localparam int N_CHECK = 6;

    typedef enum logic [CODE_W-1:0] {
        HERR_NONE      = 4'd0,
        HERR_NO_SOP    = 4'd1,
        HERR_SOP_OWN   = 4'd2,
        HERR_NULL_NEXT = 4'd3,
        HERR_NULL_BUF  = 4'd4,
        HERR_ZERO_LEN  = 4'd5,
        HERR_SHORT_PKT = 4'd6
    } herr_e;

    // checks a receive lane performs, indexed by code number
    localparam logic [N_CHECK:1] RX_CHECK_MASK = 6'b001010;
    localparam logic [N_CHECK:1] TX_CHECK_MASK = 6'b111111;

endpackage

// File: rtl/desc_lane_chk.sv
module desc_lane_chk
    import desc_chk_pkg::*;
#(
    parameter int IS_TX = 1,
    parameter int PTR_W = 32,
    parameter int LEN_W = 16,
    parameter int CH_W  = 3,
    parameter int SUM_W = LEN_W + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                d_valid,
    input  logic [CH_W-1:0]     d_chan,
    input  logic [PTR_W-1:0]    d_buf_ptr,
    input  logic [LEN_W-1:0]    d_buf_len,
    input  logic [LEN_W-1:0]    d_pkt_len,
    input  logic                d_sop,
    input  logic                d_eop,
    input  logic                d_own,
    input  logic [PTR_W-1:0]    d_next_ptr,
    input  logic                rd_clr,
    output herr_e               code_q_o,
    output logic [CH_W-1:0]     chan_q_o,
    output logic                in_pkt_q_o
);

    localparam logic [N_CHECK:1] MASK = (IS_TX != 0) ? TX_CHECK_MASK : RX_CHECK_MASK;
    localparam logic [SUM_W-1:0] SUM_MAX = '1;

    typedef struct packed {
        logic             in_pkt;
        logic [SUM_W-1:0] acc;
        logic [LEN_W-1:0] ref_len;
        herr_e            code;
        logic [CH_W-1:0]  chan;
    } lane_s;

    lane_s st_d, st_q;

    logic             start;
    logic [SUM_W-1:0] base;
    logic [SUM_W:0]   wide_sum;
    logic [SUM_W-1:0] sum;
    logic [LEN_W-1:0] ref_len;
    logic [N_CHECK:1] fault;
    logic [N_CHECK:1] hit;
    herr_e            found;

    always_comb begin
        start    = d_sop || !st_q.in_pkt;
        base     = start ? '0 : st_q.acc;
        ref_len  = start ? d_pkt_len : st_q.ref_len;
        wide_sum = {1'b0, base} + {{(SUM_W+1-LEN_W){1'b0}}, d_buf_len};
        sum      = wide_sum[SUM_W] ? SUM_MAX : wide_sum[SUM_W-1:0];

        fault[1] = !st_q.in_pkt && !d_sop;
        fault[2] = start && !d_own;
        fault[3] = !d_eop && (d_next_ptr == '0);
        fault[4] = (d_buf_ptr == '0);
        fault[5] = (d_buf_len == '0);
        fault[6] = d_eop && (ref_len != '0) &&
                   (sum < {{(SUM_W-LEN_W){1'b0}}, ref_len});
        hit = fault & MASK;

        found = HERR_NONE;
        for (int k = N_CHECK; k >= 1; k--) begin
            if (hit[k]) found = herr_e'(k);
        end

        st_d = st_q;
        if (rd_clr && (IS_TX != 0)) st_d.chan = '0;
        if (d_valid) begin
            st_d.in_pkt  = !d_eop;
            st_d.acc     = sum;
            st_d.ref_len = ref_len;
            if (st_q.code == HERR_NONE && found != HERR_NONE) begin
                st_d.code = found;
                st_d.chan = d_chan;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{in_pkt: 1'b0, acc: '0, ref_len: '0, code: HERR_NONE, chan: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q_o   = st_q.code;
    assign chan_q_o   = st_q.chan;
    assign in_pkt_q_o = st_q.in_pkt;

    AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code != HERR_NONE) |=> (st_q.code == $past(st_q.code))); // R6

    AST_OPEN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_eop) |=> st_q.in_pkt); // R2

    if (IS_TX != 0) begin : g_tx_chk
        AST_CHAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && st_q.code != HERR_NONE) |=> (st_q.chan == '0)); // R7
    end else begin : g_rx_chk
        AST_RX_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.code == HERR_NONE || st_q.code == HERR_SOP_OWN ||
             st_q.code == HERR_NULL_BUF)); // R8
        AST_RX_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.code != HERR_NONE) |=> $stable(st_q.chan)); // R8
    end

endmodule

// File: rtl/desc_stat_pack.sv
module desc_stat_pack
    import desc_chk_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            idle,
    input  herr_e           tx_code,
    input  logic [CH_W-1:0] tx_chan,
    input  herr_e           rx_code,
    input  logic [CH_W-1:0] rx_chan,
    output logic [31:0]     word
);

    always_comb begin
        word        = '0;
        word[31]    = idle;
        word[23:20] = tx_code;
        word[18:16] = tx_chan;
        word[15:12] = rx_code;
        word[10:8]  = rx_chan;
    end

endmodule

// File: rtl/desc_err_chk.sv
module desc_err_chk
    import desc_chk_pkg::*;
#(
    parameter int PTR_W = 32,
    parameter int LEN_W = 16,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    input  logic             desc_is_rx,
    input  logic [CH_W-1:0]  desc_chan,
    input  logic [PTR_W-1:0] desc_buf_ptr,
    input  logic [LEN_W-1:0] desc_buf_len,
    input  logic [LEN_W-1:0] desc_pkt_len,
    input  logic             desc_sop,
    input  logic             desc_eop,
    input  logic             desc_own,
    input  logic [PTR_W-1:0] desc_next_ptr,
    input  logic             stat_rd,
    output logic [31:0]      stat_word,
    output logic             host_err_irq
);

    localparam int N_LANE = 2;

    typedef struct packed {
        logic idle;
    } top_s;

    top_s top_d, top_q;

    logic              lane_valid [N_LANE];
    herr_e             lane_code  [N_LANE];
    logic [CH_W-1:0]   lane_chan  [N_LANE];
    logic              lane_open  [N_LANE];

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        // lane 0 checks transmit descriptors, lane 1 receive descriptors
        assign lane_valid[g] = desc_valid && (desc_is_rx == (g == 1));

        desc_lane_chk #(
            .IS_TX (g == 0 ? 1 : 0),
            .PTR_W (PTR_W),
            .LEN_W (LEN_W),
            .CH_W  (CH_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .d_valid    (lane_valid[g]),
            .d_chan     (desc_chan),
            .d_buf_ptr  (desc_buf_ptr),
            .d_buf_len  (desc_buf_len),
            .d_pkt_len  (desc_pkt_len),
            .d_sop      (desc_sop),
            .d_eop      (desc_eop),
            .d_own      (desc_own),
            .d_next_ptr (desc_next_ptr),
            .rd_clr     (stat_rd),
            .code_q_o   (lane_code[g]),
            .chan_q_o   (lane_chan[g]),
            .in_pkt_q_o (lane_open[g])
        );
    end

    always_comb begin
        top_d      = top_q;
        top_d.idle = !desc_valid && !lane_open[0] && !lane_open[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{idle: 1'b0};
        else        top_q <= top_d;
    end

    desc_stat_pack #(.CH_W(CH_W)) u_pack (
        .idle    (top_q.idle),
        .tx_code (lane_code[0]),
        .tx_chan (lane_chan[0]),
        .rx_code (lane_code[1]),
        .rx_chan (lane_chan[1]),
        .word    (stat_word)
    );

    assign host_err_irq = (lane_code[0] != HERR_NONE) || (lane_code[1] != HERR_NONE);

    AST_BUSY_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |=> !stat_word[31]); // R2

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        host_err_irq |=> host_err_irq); // R9

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word & 32'h7F08_08FF) == 32'h0); // R1

endmodule

// File: tb/tb_desc_err_chk.sv
module tb_desc_err_chk;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic        desc_is_rx = 1'b0;
    logic [2:0]  desc_chan = '0;
    logic [31:0] desc_buf_ptr = '0;
    logic [15:0] desc_buf_len = '0;
    logic [15:0] desc_pkt_len = '0;
    logic        desc_sop = 1'b0;
    logic        desc_eop = 1'b0;
    logic        desc_own = 1'b0;
    logic [31:0] desc_next_ptr = '0;
    logic        stat_rd = 1'b0;
    logic [31:0] stat_word;
    logic        host_err_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    desc_err_chk dut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_is_rx(desc_is_rx),
        .desc_chan(desc_chan), .desc_buf_ptr(desc_buf_ptr), .desc_buf_len(desc_buf_len),
        .desc_pkt_len(desc_pkt_len), .desc_sop(desc_sop), .desc_eop(desc_eop),
        .desc_own(desc_own), .desc_next_ptr(desc_next_ptr), .stat_rd(stat_rd),
        .stat_word(stat_word), .host_err_irq(host_err_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        desc_valid = 1'b0;
        stat_rd = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input bit rx, input logic [2:0] ch, input logic [31:0] ptr,
                        input logic [15:0] blen, input logic [15:0] plen,
                        input bit sop, input bit eop, input bit own, input logic [31:0] nxt);
        desc_valid = 1'b1; desc_is_rx = rx; desc_chan = ch; desc_buf_ptr = ptr;
        desc_buf_len = blen; desc_pkt_len = plen; desc_sop = sop; desc_eop = eop;
        desc_own = own; desc_next_ptr = nxt;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic host_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    function automatic logic [3:0] txc(); return stat_word[23:20]; endfunction
    function automatic logic [2:0] txch(); return stat_word[18:16]; endfunction
    function automatic logic [3:0] rxc(); return stat_word[15:12]; endfunction
    function automatic logic [2:0] rxch(); return stat_word[10:8]; endfunction

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 idle low in reset", stat_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 R2 word after reset", stat_word, 32'h8000_0000);
        chk("R9 irq low after reset", host_err_irq, 0);
    endtask

    task automatic t_good_chain();
        do_reset();
        send(0, 3'd2, 32'h100, 16'd100, 16'd600, 1, 0, 1, 32'h2000);
        chk("R2 idle low mid packet", stat_word[31], 0);
        @(negedge clk);
        chk("R2 idle low while packet open", stat_word[31], 0);
        send(0, 3'd2, 32'h200, 16'd200, 16'd0, 0, 0, 1, 32'h3000);
        send(0, 3'd2, 32'h300, 16'd300, 16'd0, 0, 1, 1, 32'h0);
        chk("R2 idle low just after EOP", stat_word[31], 0);
        @(negedge clk);
        chk("R4 R1 clean chain word", stat_word, 32'h8000_0000);
        chk("R9 no irq on clean chain", host_err_irq, 0);
    endtask

    task automatic t_single_code(input int code);
        do_reset();
        case (code)
            1: send(0, 3'd5, 32'h10, 16'd8, 16'd8, 0, 1, 1, 32'h0);
            2: send(0, 3'd5, 32'h10, 16'd8, 16'd8, 1, 1, 0, 32'h0);
            3: send(0, 3'd5, 32'h10, 16'd8, 16'd8, 1, 0, 1, 32'h0);
            4: send(0, 3'd5, 32'h0,  16'd8, 16'd8, 1, 1, 1, 32'h0);
            default: send(0, 3'd5, 32'h10, 16'd0, 16'd0, 1, 1, 1, 32'h0);
        endcase
        chk($sformatf("R3 tx code %0d", code), txc(), code);
        chk($sformatf("R7 tx chan for code %0d", code), txch(), 5);
        chk("R9 irq after fault", host_err_irq, 1);
    endtask

    task automatic t_length();
        do_reset();
        send(0, 3'd1, 32'h10, 16'd100, 16'd400, 1, 0, 1, 32'h20);
        send(0, 3'd1, 32'h20, 16'd200, 16'd0, 0, 1, 1, 32'h0);
        chk("R4 short packet code 6", txc(), 6);
        chk("R4 short packet chan", txch(), 1);
        do_reset();
        send(0, 3'd1, 32'h10, 16'd100, 16'd300, 1, 0, 1, 32'h20);
        send(0, 3'd1, 32'h20, 16'd200, 16'd0, 0, 1, 1, 32'h0);
        chk("R4 exact sum no error", txc(), 0);
        do_reset();
        send(0, 3'd1, 32'h10, 16'd4, 16'd0, 1, 1, 1, 32'h0);
        chk("R4 zero packet length not flagged", txc(), 0);
        do_reset();
        // SOP restarts the sum: 250 from the broken packet must not count
        send(0, 3'd1, 32'h10, 16'd250, 16'd999, 1, 0, 1, 32'h20);
        send(0, 3'd1, 32'h10, 16'd50, 16'd300, 1, 1, 1, 32'h0);
        chk("R4 SOP restarts sum", txc(), 6);
    endtask

    task automatic t_priority();
        do_reset();
        send(0, 3'd3, 32'h0, 16'd0, 16'd0, 0, 1, 0, 32'h0);
        chk("R5 lowest code wins (1)", txc(), 1);
        do_reset();
        send(0, 3'd3, 32'h10, 16'd0, 16'd0, 1, 0, 0, 32'h0);
        chk("R5 lowest code wins (2)", txc(), 2);
        do_reset();
        send(0, 3'd3, 32'h0, 16'd0, 16'd0, 1, 1, 1, 32'h0);
        chk("R5 lowest code wins (4)", txc(), 4);
    endtask

    task automatic t_sticky_and_read();
        do_reset();
        send(0, 3'd6, 32'h0, 16'd8, 16'd8, 1, 1, 1, 32'h0);
        send(0, 3'd2, 32'h10, 16'd8, 16'd8, 0, 1, 1, 32'h0);
        chk("R6 first code kept", txc(), 4);
        chk("R6 first chan kept", txch(), 6);
        host_read();
        chk("R7 chan cleared by read", txch(), 0);
        chk("R7 code kept after read", txc(), 4);
        chk("R9 irq kept after read", host_err_irq, 1);
        do_reset();
        stat_rd = 1'b1;
        send(0, 3'd7, 32'h0, 16'd8, 16'd8, 1, 1, 1, 32'h0);
        stat_rd = 1'b0;
        chk("R7 latch wins over read", txch(), 7);
    endtask

    task automatic t_rx();
        do_reset();
        send(1, 3'd4, 32'h10, 16'd0, 16'd0, 0, 0, 1, 32'h0);
        chk("R8 rx ignores tx-only faults", rxc(), 0);
        chk("R8 tx untouched by rx", txc(), 0);
        @(negedge clk);
        chk("R8 R2 rx packet open keeps idle low", stat_word[31], 0);
        send(1, 3'd4, 32'h10, 16'd4, 16'd0, 0, 1, 1, 32'h0);
        send(1, 3'd4, 32'h10, 16'd4, 16'd0, 1, 1, 0, 32'h0);
        chk("R8 rx code 2", rxc(), 2);
        chk("R8 rx chan", rxch(), 4);
        chk("R9 irq on rx fault", host_err_irq, 1);
        host_read();
        chk("R8 rx chan not cleared by read", rxch(), 4);
        do_reset();
        send(1, 3'd3, 32'h0, 16'd4, 16'd0, 1, 1, 1, 32'h0);
        chk("R8 rx code 4", rxc(), 4);
        chk("R1 rx word layout", stat_word, 32'h0000_4300);
    endtask

    initial begin
        t_reset();
        t_good_chain();
        for (int c = 1; c <= 5; c++) t_single_code(c);
        t_length();
        t_priority();
        t_sticky_and_read();
        t_rx();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule